// File: doc/BRIEF.md
# Latched Event Status with Interrupt Pin

This block collects single-cycle event pulses into sticky status bits, grouped into banks of equal width. Each status bit has a matching enable bit. The interrupt pin is active low. It is asserted while any status bit that is set also has its enable bit set. A simple synchronous strobe port gives a host read and write access to a control register, the status banks and the enable banks. Read data comes back one cycle after the read strobe.

Two control bits are set at run time:
- **Clear policy.** One bit selects how status bits are cleared. They are either cleared by writing ones to them, or cleared as a side effect of reading their bank.
- **Pin idle behaviour.** The other bit selects how the pin behaves when no interrupt is pending. It either releases the pin (output-enable low, for a shared open-drain line) or drives it high.

Two reset inputs are provided. A soft reset returns every register to its default. A data-path reset empties only the status latches.

Top module: `evt_latch_irq`

## Requirements
- R1: A pulse on an event input sets its status bit one cycle later. The bit then stays set until it is cleared by one of the clear actions in R2, R3, R9 or R10.
- R2: With the clear-select bit (control bit 0) at 0, a write to a status bank clears exactly the bits written as 1 and leaves the others unchanged. Reads do not change status in this mode.
- R3: With the clear-select bit at 1, a read of a status bank returns the value held before the read and clears that whole bank. Writes to a status bank are ignored in this mode.
- R4: An event that arrives in the same cycle as a clear of its bit leaves the bit set, under either clear policy.
- R5: The interrupt is pending exactly when some status bit and its enable bit are both 1. The pin outputs follow this condition one clock after the status changes.
- R6: While an interrupt is pending, irq_n_o is 0 and irq_oe_o is 1.
- R7: While no interrupt is pending and the pin-drive bit (control bit 1) is 0, irq_oe_o is 0.
- R8: While no interrupt is pending and the pin-drive bit is 1, irq_oe_o is 1 and irq_n_o is 1.
- R9: rst_i and soft_rst_i each return the control register, all enables and all status bits to 0. Events are not latched while either reset is high.
- R10: dp_rst_i clears all status bits and ignores events. It leaves the control register and the enables unchanged.
- R11: The address map is as follows. Address 0 is the control register. Address 1+k is status bank k. Address 1+NUM_BANKS+k is enable bank k. Any other address reads 0. host_rvld_o rises one cycle after host_rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| soft_rst_i | input | 1 | Soft reset of all registers |
| dp_rst_i | input | 1 | Clears status latches only |
| evt_i | input | NUM_BANKS*BANK_W | Event pulses, bank k at bits [k*BANK_W +: BANK_W] |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe |
| host_addr_i | input | ADDR_W | Register address |
| host_wdata_i | input | BANK_W | Write data |
| host_rdata_o | output | BANK_W | Read data, registered |
| host_rvld_o | output | 1 | Read data valid |
| irq_n_o | output | 1 | Interrupt pin value, active low |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with NUM_BANKS=3 and BANK_W=6. With these values the address space is 3 bits wide and only 7 of its 8 addresses are mapped. This makes it possible to check that an unmapped address reads back 0. It also makes the last enable bank sit at the top mapped address, and puts an event bit at the highest position of the flattened event bus. The bench checks every clear path under both policies, with events landing in the same cycle as the clear. It checks the pin outputs in all three of their states.

// File: rtl/eli_pkg.sv
package eli_pkg;
  // control register layout: bit 1 pin drive, bit 0 clear-on-read
  typedef struct packed {
    logic pin_drive;
    logic clr_on_rd;
  } eli_ctrl_t;

  localparam int CTRL_W = 2;
endpackage

// File: rtl/eli_ctrl_reg.sv
module eli_ctrl_reg
  import eli_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output eli_ctrl_t         ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_en)
      ctrl_q <= eli_ctrl_t'(wdata);
  end

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/eli_sts_bank.sv
module eli_sts_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dp_rst,
  input  logic         rc_mode,
  input  logic [W-1:0] evt,
  input  logic         sts_wr,
  input  logic         sts_rd,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sts_q,
  output logic [W-1:0] en_q,
  output logic         act
);
  logic [W-1:0] clr_mask;
  logic         clr_hit;

  always_comb begin
    clr_mask = '0;
    if (rc_mode) begin
      if (sts_rd) clr_mask = '1;
    end else begin
      if (sts_wr) clr_mask = wdata;
    end
  end

  assign clr_hit = rc_mode ? sts_rd : sts_wr;

  always_ff @(posedge clk) begin
    if (rst || dp_rst)
      sts_q <= '0;
    else
      sts_q <= (sts_q & ~clr_mask) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (en_wr)
      en_q <= wdata;
  end

  assign act = |(sts_q & en_q);

  // R1 R4
  evt_lands_chk: assert property (@(posedge clk) disable iff (rst || dp_rst)
    (evt != '0) |=> ((sts_q & $past(evt)) == $past(evt)));

  // R1 R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst || dp_rst)
    !clr_hit |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R10
  dp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    dp_rst |=> (sts_q == '0));
endmodule

// File: rtl/eli_irq_drv.sv
module eli_irq_drv (
  input  logic clk,
  input  logic rst,
  input  logic any_act,
  input  logic pin_drive,
  output logic irq_n,
  output logic irq_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n  <= 1'b1;
      irq_oe <= 1'b0;
    end else if (any_act) begin
      irq_n  <= 1'b0;
      irq_oe <= 1'b1;
    end else begin
      irq_n  <= 1'b1;
      irq_oe <= pin_drive;
    end
  end

  // R6
  irq_active_chk: assert property (@(posedge clk) disable iff (rst)
    any_act |=> (!irq_n && irq_oe));

  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_act && !pin_drive) |=> !irq_oe);

  // R8
  irq_drive_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_act && pin_drive) |=> (irq_n && irq_oe));
endmodule

// File: rtl/evt_latch_irq.sv
module evt_latch_irq
  import eli_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 8,
  localparam int ADDR_W   = $clog2(2 * NUM_BANKS + 1),
  localparam int EVT_W    = NUM_BANKS * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              soft_rst_i,
  input  logic              dp_rst_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BANK_W-1:0] host_wdata_i,
  output logic [BANK_W-1:0] host_rdata_o,
  output logic              host_rvld_o,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  logic                    g_rst;
  eli_ctrl_t               ctrl_q;
  logic                    ctrl_wr;
  logic [BANK_W-1:0]       sts_arr [NUM_BANKS];
  logic [BANK_W-1:0]       en_arr  [NUM_BANKS];
  logic [NUM_BANKS-1:0]    act_v;
  logic [BANK_W-1:0]       rdata_d;

  assign g_rst   = rst_i | soft_rst_i;
  assign ctrl_wr = host_wr_i && (host_addr_i == '0);

  eli_ctrl_reg u_ctrl (
    .clk    (clk_i),
    .rst    (g_rst),
    .wr_en  (ctrl_wr),
    .wdata  (host_wdata_i[CTRL_W-1:0]),
    .ctrl_q (ctrl_q)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(1 + k);
    localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(1 + NUM_BANKS + k);

    eli_sts_bank #(.W(BANK_W)) u_bank (
      .clk     (clk_i),
      .rst     (g_rst),
      .dp_rst  (dp_rst_i),
      .rc_mode (ctrl_q.clr_on_rd),
      .evt     (evt_i[k*BANK_W +: BANK_W]),
      .sts_wr  (host_wr_i && (host_addr_i == STS_A)),
      .sts_rd  (host_rd_i && (host_addr_i == STS_A)),
      .en_wr   (host_wr_i && (host_addr_i == EN_A)),
      .wdata   (host_wdata_i),
      .sts_q   (sts_arr[k]),
      .en_q    (en_arr[k]),
      .act     (act_v[k])
    );
  end

  always_comb begin
    rdata_d = '0;
    if (host_addr_i == '0)
      rdata_d = BANK_W'(ctrl_q);
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (host_addr_i == ADDR_W'(1 + k))
        rdata_d = sts_arr[k];
      if (host_addr_i == ADDR_W'(1 + NUM_BANKS + k))
        rdata_d = en_arr[k];
    end
  end

  always_ff @(posedge clk_i) begin
    if (g_rst) begin
      host_rdata_o <= '0;
      host_rvld_o  <= 1'b0;
    end else begin
      host_rvld_o <= host_rd_i;
      if (host_rd_i)
        host_rdata_o <= rdata_d;
    end
  end

  eli_irq_drv u_irq (
    .clk       (clk_i),
    .rst       (g_rst),
    .any_act   (|act_v),
    .pin_drive (ctrl_q.pin_drive),
    .irq_n     (irq_n_o),
    .irq_oe    (irq_oe_o)
  );

  // R11
  rvld_follow_chk: assert property (@(posedge clk_i) disable iff (g_rst)
    host_rd_i |=> host_rvld_o);

  // R9
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    soft_rst_i |=> (irq_n_o && !irq_oe_o && !host_rvld_o));
endmodule

// File: tb/sim_evt_latch_irq.sv
module sim_evt_latch_irq;
  localparam int NB = 3;
  localparam int W  = 6;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_i, soft_rst_i, dp_rst_i;
  logic [NB*W-1:0] evt_i;
  logic          host_wr_i, host_rd_i;
  logic [AW-1:0] host_addr_i;
  logic [W-1:0]  host_wdata_i;
  logic [W-1:0]  host_rdata_o;
  logic          host_rvld_o, irq_n_o, irq_oe_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evt_latch_irq #(.NUM_BANKS(NB), .BANK_W(W)) u0 (
    .clk_i(clk), .rst_i(rst_i), .soft_rst_i(soft_rst_i), .dp_rst_i(dp_rst_i),
    .evt_i(evt_i), .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
    .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o), .host_rvld_o(host_rvld_o),
    .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks begin and end at a falling edge
  task automatic host_write(int a, int d);
    host_wr_i = 1'b1; host_addr_i = AW'(a); host_wdata_i = W'(d);
    @(negedge clk);
    host_wr_i = 1'b0;
  endtask

  task automatic host_read(int a, output int d, output int v);
    host_rd_i = 1'b1; host_addr_i = AW'(a);
    @(negedge clk);
    host_rd_i = 1'b0;
    d = int'(host_rdata_o);
    v = int'(host_rvld_o);
  endtask

  task automatic read_chk(string req, int a, int exp);
    int d, v;
    host_read(a, d, v);
    check(req, v, 1);
    check(req, d, exp);
  endtask

  task automatic pulse(int vec);
    evt_i = (NB*W)'(vec);
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    check("R9 irq_oe after reset", int'(irq_oe_o), 0);
    check("R9 irq_n after reset", int'(irq_n_o), 1);
    read_chk("R9 ctrl default", 0, 0);
    read_chk("R9 status default", 1, 0);
  endtask

  task automatic t_latch();
    pulse(6'h05);
    read_chk("R1 latched bits", 1, 'h05);
    repeat (3) @(negedge clk);
    read_chk("R1 R2 held after read in write-clear mode", 1, 'h05);
    check("R5 R7 no enable no irq", int'(irq_oe_o), 0);
  endtask

  task automatic t_enable();
    host_write(4, 'h04);
    @(negedge clk);
    check("R5 R6 irq_n pending", int'(irq_n_o), 0);
    check("R6 irq_oe pending", int'(irq_oe_o), 1);
  endtask

  task automatic t_w1c();
    host_write(1, 'h01);
    read_chk("R2 only written ones cleared", 1, 'h04);
    check("R5 still pending", int'(irq_n_o), 0);
    host_write(1, 'h04);
    read_chk("R2 last bit cleared", 1, 'h00);
    check("R5 R7 irq released after clear", int'(irq_oe_o), 0);
  endtask

  task automatic t_coincident_w1c();
    pulse(6'h02);
    evt_i = (NB*W)'(6'h02);
    host_write(1, 'h02);
    evt_i = '0;
    read_chk("R4 event kept against write clear", 1, 'h02);
    host_write(1, 'h02);
    read_chk("R2 cleared afterwards", 1, 'h00);
  endtask

  task automatic t_readclear();
    host_write(0, 'h01);
    pulse('h21 << W);
    host_write(2, 'h21);
    read_chk("R3 write ignored, pre-clear value", 2, 'h21);
    read_chk("R3 bank cleared by read", 2, 'h00);
    pulse('h08 << W);
    evt_i = (NB*W)'('h08 << W);
    read_chk("R3 R4 read with event", 2, 'h08);
    evt_i = '0;
    read_chk("R4 event kept against read clear", 2, 'h08);
    read_chk("R3 cleared by later read", 2, 'h00);
  endtask

  task automatic t_pinmode();
    host_write(0, 'h02);
    @(negedge clk);
    check("R8 idle drive high oe", int'(irq_oe_o), 1);
    check("R8 idle drive high value", int'(irq_n_o), 1);
    read_chk("R11 ctrl readback", 0, 'h02);
  endtask

  task automatic t_map();
    host_write(6, 'h3F);
    read_chk("R11 top enable bank", 6, 'h3F);
    read_chk("R11 unmapped address", 7, 0);
    pulse(1 << 17);
    @(negedge clk);
    check("R6 irq from last bank", int'(irq_n_o), 0);
    read_chk("R11 status bank 2", 3, 'h20);
  endtask

  task automatic t_dprst();
    dp_rst_i = 1'b1;
    evt_i = (NB*W)'(1);
    @(negedge clk);
    dp_rst_i = 1'b0;
    evt_i = '0;
    read_chk("R10 status emptied", 3, 0);
    read_chk("R10 event ignored in dp reset", 1, 0);
    read_chk("R10 enable kept", 6, 'h3F);
    read_chk("R10 ctrl kept", 0, 'h02);
    check("R10 R8 irq idle drive high", int'(irq_oe_o), 1);
  endtask

  task automatic t_softrst();
    pulse(6'h10);
    soft_rst_i = 1'b1;
    evt_i = (NB*W)'(6'h01);
    @(negedge clk);
    soft_rst_i = 1'b0;
    evt_i = '0;
    read_chk("R9 ctrl cleared", 0, 0);
    read_chk("R9 enable cleared", 6, 0);
    read_chk("R9 status cleared", 1, 0);
    check("R9 R7 pin released", int'(irq_oe_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_i = 1'b1; soft_rst_i = 1'b0; dp_rst_i = 1'b0; evt_i = '0;
    host_wr_i = 1'b0; host_rd_i = 1'b0; host_addr_i = '0; host_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_enable();
    t_w1c();
    t_coincident_w1c();
    t_readclear();
    t_pinmode();
    t_map();
    t_dprst();
    t_softrst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule